// File: doc/BRIEF.md
# Double-Buffered Serial Word Transmitter

This block takes a 32-bit word from a host as two 16-bit halves and sends it out serially. The host writes each half through an active-low write strobe, and an address input chooses the half. The word then leaves one bit per bit period, least significant bit first, and a fixed gap of four idle bit periods follows it. A holding buffer separates the host side from the shifter, so the host can write the next word while the current one is still on the line. A ready flag tells the host when the buffer can take new data. The last bit of the word can carry odd parity in place of data.

The bit period is two cycles of `clk`. The first cycle is the high phase of the exported bit clock and the second is the low phase. Two drive enables, A and B, carry each bit in return-to-zero form for an external line driver. A separate NRZ data pin holds each bit for its full period. An active-low sync pulse marks the eighth bit of every word. All inputs are sampled on the rising edge of `clk`.

Top module: `arinc_word_serializer`

## Requirements
- R1: While `rst_n` is low and after it is released, `ready` is 1, `tx_a`, `tx_b` and `nrz` are 0 and `sync_n` is 1. The line stays idle until a complete word has been written.
- R2: A write is taken on the rising edge of `wr_n` that ends a low pulse, using the `din` and `addr` values present at that edge. `addr`=1 writes word bits 15:0 (the first half). `addr`=0 writes word bits 31:16 (the second half).
- R3: `ready` goes to 0 in the cycle after the second-half write is taken. It returns to 1 when the buffer moves into the shifter, and that move always happens at the end of a bit period.
- R4: A write presented while `ready` is 0 has no effect on the buffered word.
- R5: A word goes out as 32 bits, bit 0 first and bit 31 last, one bit per bit period.
- R6: With `par_en`=1 when the word is moved into the shifter, bit 31 is sent so that the 32 sent bits contain an odd number of ones. With `par_en`=0, bit 31 is bit 15 of the second half.
- R7: When the next word is already buffered before the fourth gap bit of the current word ends, exactly 4 idle bit periods separate the two words. The move into the shifter happens at the end of that fourth gap bit.
- R8: When the second half is written after the fourth gap bit has passed, the move happens at the end of the current bit period. `ready` is back at 1 no more than 2 cycles after it fell.
- R9: `bit_clk` is 1 in the first cycle of each bit period and 0 in the second. For a 1 bit, `tx_a` is 1 during the first cycle. For a 0 bit, `tx_b` is 1 during the first cycle. Both are 0 during the second cycle, during the gap and while idle, and they are never 1 together.
- R10: `nrz` equals the current data bit for both cycles of its bit period and is 0 during the gap and while idle.
- R11: `sync_n` is 0 only in the second cycle (with `bit_clk`=0) of the 8th bit of a word, and 1 at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, two cycles per bit period |
| rst_n | input | 1 | Active-low reset |
| wr_n | input | 1 | Active-low write strobe; data is taken on its rising edge |
| addr | input | 1 | Half select: 1 for the first half (bits 15:0), 0 for the second half (bits 31:16) |
| din | input | 16 | Half-word data |
| par_en | input | 1 | Puts odd parity in bit 31 |
| ready | output | 1 | High while the holding buffer is empty |
| bit_clk | output | 1 | Bit clock, high in the first half of each bit period |
| tx_a | output | 1 | Return-to-zero drive enable for a 1 bit |
| tx_b | output | 1 | Return-to-zero drive enable for a 0 bit |
| nrz | output | 1 | NRZ serial data |
| sync_n | output | 1 | Active-low sync pulse in the second half of bit 8 |

## Verification
The assertions on the ready flag assume that `wr_n` is held high during reset. They also assume every strobe is a clean low pulse of at least one cycle, so that a fall of `ready` can be traced back to a rising strobe edge with `addr` low. The bench drives every input on the falling edge of `clk`, keeps `wr_n` high through reset, and uses one-cycle low pulses with `addr` and `din` held steady around the edge. It changes `par_en` only while the buffer is empty, so the parity setting for each word is known when that word moves into the shifter.

// File: rtl/arinc_word_serializer.sv
module arinc_word_serializer #(
  parameter int HALF_W   = 16,
  parameter int GAP_BITS = 4,
  parameter int SYNC_BIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              addr,
  input  logic [HALF_W-1:0] din,
  input  logic              par_en,
  output logic              ready,
  output logic              bit_clk,
  output logic              tx_a,
  output logic              tx_b,
  output logic              nrz,
  output logic              sync_n
);
  localparam int WORD_W = 2 * HALF_W;
  localparam int LAST   = WORD_W + GAP_BITS - 1;
  localparam int CW     = $clog2(LAST + 1);

  logic              wr_q, full, ph, idle;
  logic [HALF_W-1:0] lo_q, hi_q;
  logic [WORD_W-1:0] shreg, word_nx;
  logic [CW-1:0]     cnt;

  wire strobe   = !wr_q && wr_n && !full;
  wire sending  = !idle && (cnt < CW'(WORD_W));
  wire load_now = ph && full && (idle || cnt == CW'(LAST));

  always_comb begin
    word_nx = {hi_q, lo_q};
    if (par_en) word_nx[WORD_W-1] = ~^word_nx[WORD_W-2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= 1'b1;
      full  <= 1'b0;
      ph    <= 1'b0;
      idle  <= 1'b1;
      lo_q  <= '0;
      hi_q  <= '0;
      shreg <= '0;
      cnt   <= '0;
    end else begin
      wr_q <= wr_n;
      ph   <= ~ph;
      if (strobe) begin
        if (addr) lo_q <= din;
        else begin
          hi_q <= din;
          full <= 1'b1;
        end
      end
      if (ph) begin
        if (load_now) begin
          shreg <= word_nx;
          cnt   <= '0;
          idle  <= 1'b0;
          full  <= 1'b0;
        end else if (!idle) begin
          shreg <= {1'b0, shreg[WORD_W-1:1]};
          if (cnt == CW'(LAST)) idle <= 1'b1;
          else cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign ready   = !full;
  assign bit_clk = !ph;
  assign tx_a    = sending && shreg[0] && !ph;
  assign tx_b    = sending && !shreg[0] && !ph;
  assign nrz     = sending && shreg[0];
  assign sync_n  = !(sending && ph && cnt == CW'(SYNC_BIT - 1));
endmodule

module arinc_word_serializer_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_n,
  input logic addr,
  input logic ready,
  input logic bit_clk,
  input logic tx_a,
  input logic tx_b,
  input logic nrz,
  input logic sync_n
);
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_a && tx_b));
  p_rtz_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_clk |-> (!tx_a && !tx_b));
  p_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_clk |=> !bit_clk);
  p_nrz_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_clk && (tx_a || tx_b)) |-> (nrz == tx_a));
  p_nrz_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_clk && (tx_a || tx_b)) |=> $stable(nrz));
  p_sync_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |-> (!bit_clk && $past(tx_a || tx_b)));
  p_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> ($past(wr_n) && !$past(addr) && !$past(wr_n, 2)));
  p_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (bit_clk && !$past(bit_clk)));
endmodule

bind arinc_word_serializer arinc_word_serializer_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .addr(addr), .ready(ready),
  .bit_clk(bit_clk), .tx_a(tx_a), .tx_b(tx_b), .nrz(nrz), .sync_n(sync_n)
);

// File: tb/test_arinc_word_serializer.sv
module test_arinc_word_serializer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_n = 1'b1;
  logic        addr = 1'b0;
  logic [15:0] din = '0;
  logic        par_en = 1'b0;
  logic        ready, bit_clk, tx_a, tx_b, nrz, sync_n;

  int checks = 0;
  int fails = 0;

  logic [31:0] q_word[$];
  bit          q_tight[$];
  bit          q_par[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  arinc_word_serializer i_arinc_word_serializer (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .addr(addr), .din(din),
    .par_en(par_en), .ready(ready), .bit_clk(bit_clk), .tx_a(tx_a),
    .tx_b(tx_b), .nrz(nrz), .sync_n(sync_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    addr = a; din = d; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [31:0] expect_word(input logic [15:0] lo,
                                              input logic [15:0] hi, input bit p);
    logic [31:0] w;
    w = {hi, lo};
    if (p) w[31] = ~^w[30:0];
    return w;
  endfunction

  task automatic send(input logic [15:0] lo, input logic [15:0] hi, input bit p,
                      input bit tight, input bit junk);
    while (!ready) @(negedge clk);
    par_en = p;
    q_word.push_back(expect_word(lo, hi, p));
    q_tight.push_back(tight);
    q_par.push_back(p);
    wr(1'b1, lo);
    chk(ready == 1'b1, "R3 first half keeps ready", 32'(ready), 32'd1);
    wr(1'b0, hi);
    chk(ready == 1'b0, "R3 ready low after second half", 32'(ready), 32'd0);
    if (junk) begin
      wr(1'b1, ~lo);
      wr(1'b0, ~hi);
      chk(ready == 1'b0, "R4 ready after ignored writes", 32'(ready), 32'd0);
    end
  endtask

  // line monitor
  int          nb = 0;
  int          gap = 0;
  bit          seen = 0;
  logic [31:0] rx = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (bit_clk) begin
        if (tx_a || tx_b) begin
          chk(!(tx_a && tx_b), "R9 exclusive enables", {tx_a, tx_b}, 32'd0);
          chk(nrz == tx_a, "R10 nrz matches bit", 32'(nrz), 32'(tx_a));
          if (nb == 0 && seen && q_word.size() > 0) begin
            if (q_tight[0]) chk(gap == 4, "R7 gap length", gap, 32'd4);
            else chk(gap >= 4, "R7 minimum gap", gap, 32'd4);
          end
          if (nb < 32) rx[nb] = tx_a;
          nb++;
          gap = 0;
          if (nb == 32) begin
            seen = 1;
            if (q_word.size() == 0) chk(0, "R5 unexpected word", rx, 32'd0);
            else begin
              chk(rx == q_word[0], q_par[0] ? "R6 word with parity" : "R5 word content",
                  rx, q_word[0]);
              void'(q_word.pop_front());
              void'(q_tight.pop_front());
              void'(q_par.pop_front());
            end
          end
        end else begin
          chk(nrz == 1'b0, "R10 nrz low in gap", 32'(nrz), 32'd0);
          gap++;
          nb = 0;
        end
        chk(sync_n == 1'b1, "R11 sync high in first half", 32'(sync_n), 32'd1);
      end else begin
        chk(!tx_a && !tx_b, "R9 return to zero", {tx_a, tx_b}, 32'd0);
        chk(sync_n == !(nb == 8), "R11 sync on bit 8", 32'(sync_n), 32'(!(nb == 8)));
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [15:0] lcg;
    lcg = 16'hACE1;
    repeat (3) @(negedge clk);
    chk(ready == 1'b1, "R1 ready in reset", 32'(ready), 32'd1);
    chk({tx_a, tx_b, nrz} == 3'b000, "R1 line idle in reset", {tx_a, tx_b, nrz}, 32'd0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(ready == 1'b1, "R1 ready after reset", 32'(ready), 32'd1);
    chk({tx_a, tx_b, nrz} == 3'b000, "R1 line idle after reset", {tx_a, tx_b, nrz}, 32'd0);
    chk(sync_n == 1'b1, "R1 sync idle", 32'(sync_n), 32'd1);
    wr(1'b1, 16'h1234);
    repeat (20) @(negedge clk);
    chk({tx_a, tx_b, nrz} == 3'b000, "R2 half word does not start line",
        {tx_a, tx_b, nrz}, 32'd0);

    // back-to-back sweep (R2 R5 R6 R7)
    for (int i = 0; i < 40; i++) begin
      logic [15:0] lo, hi;
      lcg = lcg * 16'd25173 + 16'd13849;
      case (i)
        0: begin lo = 16'h0000; hi = 16'h0000; end
        1: begin lo = 16'hFFFF; hi = 16'hFFFF; end
        2: begin lo = 16'h5555; hi = 16'hAAAA; end
        3: begin lo = 16'h8001; hi = 16'h8000; end
        default: begin lo = (i < 20) ? (16'h1 << (i - 4)) : lcg; hi = lcg ^ 16'(i * 16'h0F0F); end
      endcase
      send(lo, hi, i[0] ^ i[2], i != 0, i % 7 == 3);
    end
    while (q_word.size() != 0) @(negedge clk);

    // idle loads (R8)
    for (int k = 0; k < 6; k++) begin
      repeat (60 + k) @(negedge clk);
      send(16'h0F0F ^ 16'(k), 16'hC3C3 + 16'(k), k[0], 1'b0, 1'b0);
      repeat (2) @(negedge clk);
      chk(ready == 1'b1, "R8 immediate transfer when idle", 32'(ready), 32'd1);
      while (q_word.size() != 0) @(negedge clk);
    end
    repeat (20) @(negedge clk);
    summary();
  end
endmodule